// File: doc/BRIEF.md
# Vector Length Strip-Mining Sequencer

This block runs the element loop of a vector unit for a scaled-add style operation over `n` elements. A request carries the element count, the hardware's maximum vector length (counted in 64-bit elements) and an element-width select. The block cuts the work into strips. At the start of each strip it grants a vector length equal to the smaller of the scaled maximum length and the elements still outstanding. It also reports the byte stride by which the x and y pointers advance. It then issues the strip as groups of lanes, one group per clock, with a lane-enable mask that switches off lanes past the end of the strip.

Narrower elements pack more of them into a register. So both the maximum vector length and the number of lanes per clock double each time the element width halves. A request of zero elements produces one grant of length zero and no issue cycles. The loop therefore needs no separate code for a tail or for an empty request. The arithmetic datapath, the memories and instruction decode sit outside this block.

Top module: `vl_strip_seq`

## Requirements
- R1: On a grant cycle (`strip_valid` high), `vl_o` equals the smaller of the effective maximum length and the elements still outstanding.
- R2: After each grant the outstanding count drops by the granted length. Strips repeat until it reaches zero. `done_o` is high for exactly one cycle, in the cycle after the last issue group, and the block is idle on the cycle after that.
- R3: A request with `n_i` = 0 gives one grant cycle with `vl_o` = 0 and `stride_o` = 0, no issue cycles, and `done_o` on the next cycle.
- R4: `LANES64` must be 2, 4 or 8. Any other value stops elaboration.
- R5: Issue cycles of a strip carry `base_o` = 0, LE, 2·LE, … where LE is the lanes per clock. `lane_en_o` bit i is set only when i < LE and `base_o`+i < `vl_o` of that strip. The last group of a strip is partial when the granted length is not a multiple of LE.
- R6: `ew_i` encodes 0 = 64-bit, 1 = 32-bit, 2 = 16-bit and 3 = 8-bit elements. The effective maximum length is `mvl64_i` << `ew_i` and LE is `LANES64` << `ew_i`.
- R7: On a grant cycle `stride_o` equals `vl_o` × (8 >> `ew_i`) bytes. When not granting it is 0.
- R8: `start_ready` is high only when the block is idle. A request is taken on a clock edge where `start_valid` and `start_ready` are both high. `n_i`, `ew_i` and `mvl64_i` are captured then, and the first grant appears in the next cycle.
- R9: `start_valid` asserted while the block is busy has no effect. The running operation's grants, masks and done timing are unchanged, and the ignored request is never started.
- R10: After reset the block is idle with `start_ready` high and every valid output, mask, length, stride and index at 0. `lane_en_o` is 0 on every cycle that is not an issue cycle.
- R11: An `mvl64_i` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request strobe |
| start_ready | output | 1 | High while idle; request accepted when both are high |
| n_i | input | CNT_W | Element count of the request |
| ew_i | input | 2 | Element width select (0=64, 1=32, 2=16, 3=8 bits) |
| mvl64_i | input | MVL_W | Maximum vector length in 64-bit elements |
| strip_valid | output | 1 | Grant cycle of a strip |
| vl_o | output | CNT_W | Granted vector length (grant cycles only) |
| stride_o | output | CNT_W+3 | Pointer advance in bytes (grant cycles only) |
| issue_valid | output | 1 | An element group is issued this cycle |
| base_o | output | CNT_W | First element index of the issued group |
| lane_en_o | output | 8·LANES64 | Per-lane enable of the issued group |
| done_o | output | 1 | One-cycle pulse after the last group |

## Verification
Every result has a fixed cycle. The first grant is visible one cycle after the accepting edge. Each issue group follows one cycle after the grant or the previous group. The next grant or `done_o` follows one cycle after the last group, and idle one cycle after `done_o`. The bench turns each request into a queue of expected per-cycle records, starting with the cycle after acceptance. Between the falling edges it pops one record and compares every output against it, and it expects the idle record whenever the queue is empty. A late grant or an extra issue cycle therefore shows up as a mismatch in that very cycle.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GRANT = 2'd1,
      ST_ISSUE = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

   // element width select codes
   localparam logic [1:0] EW_64 = 2'd0;
   localparam logic [1:0] EW_32 = 2'd1;
   localparam logic [1:0] EW_16 = 2'd2;
   localparam logic [1:0] EW_8  = 2'd3;

   // log2 of the element size in bytes for a width select
   function automatic logic [1:0] bytes_log2(input logic [1:0] ew);
      return 2'd3 - ew;
   endfunction
endpackage

// File: rtl/vlseq_grant.sv
module vlseq_grant #(
   parameter int CNT_W = 16,
   parameter int MVL_W = 8
) (
   input  logic [CNT_W-1:0] rem_i,
   input  logic [MVL_W-1:0] mvl64_i,
   input  logic [1:0]       ew_i,
   output logic [CNT_W-1:0] vl_o,
   output logic [CNT_W+2:0] stride_o
);
   import vlseq_pkg::*;

   localparam int EXT_W = (CNT_W > MVL_W + 3) ? CNT_W : MVL_W + 3;

   logic [MVL_W-1:0] mvl_nz;
   logic [EXT_W-1:0] mvl_x;
   logic [EXT_W-1:0] rem_x;
   logic [EXT_W-1:0] vl_x;
   logic [CNT_W+2:0] vl_w;

   always_comb begin
      mvl_nz   = (mvl64_i == '0) ? MVL_W'(1) : mvl64_i;
      mvl_x    = EXT_W'(mvl_nz) << ew_i;
      rem_x    = EXT_W'(rem_i);
      vl_x     = (mvl_x < rem_x) ? mvl_x : rem_x;
      vl_o     = vl_x[CNT_W-1:0];
      vl_w     = {3'b000, vl_o};
      stride_o = vl_w << bytes_log2(ew_i);
   end
endmodule

// File: rtl/vlseq_lane_mask.sv
module vlseq_lane_mask #(
   parameter int LMAX  = 32,
   parameter int CNT_W = 16,
   parameter int LW    = 6
) (
   input  logic [CNT_W-1:0] base_i,
   input  logic [CNT_W-1:0] vl_i,
   input  logic [LW-1:0]    lanes_i,
   output logic [LMAX-1:0]  en_o
);
   for (genvar g = 0; g < LMAX; g++) begin : g_lane
      logic [CNT_W:0] idx;
      assign idx     = {1'b0, base_i} + (CNT_W+1)'(g);
      assign en_o[g] = (LW'(g) < lanes_i) && (idx < {1'b0, vl_i});
   end
endmodule

// File: rtl/vl_strip_seq.sv
module vl_strip_seq #(
   parameter int LANES64 = 4,
   parameter int CNT_W   = 16,
   parameter int MVL_W   = 8,
   parameter int LMAX    = LANES64 * 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_valid,
   output logic                 start_ready,
   input  logic [CNT_W-1:0]     n_i,
   input  logic [1:0]           ew_i,
   input  logic [MVL_W-1:0]     mvl64_i,
   output logic                 strip_valid,
   output logic [CNT_W-1:0]     vl_o,
   output logic [CNT_W+2:0]     stride_o,
   output logic                 issue_valid,
   output logic [CNT_W-1:0]     base_o,
   output logic [LMAX-1:0]      lane_en_o,
   output logic                 done_o
);
   import vlseq_pkg::*;

   localparam int LW = $clog2(LMAX) + 1;

   // elaboration checks (R4)
   if (!(LANES64 == 2 || LANES64 == 4 || LANES64 == 8)) begin : g_bad_lanes
      $error("LANES64 must be 2, 4 or 8");
   end
   if (LMAX != LANES64 * 8) begin : g_bad_lmax
      $error("LMAX must equal 8*LANES64");
   end
   if (CNT_W < LW + 1) begin : g_bad_cnt
      $error("CNT_W too narrow for the lane count");
   end

   seq_state_e       state_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] vl_q;
   logic [CNT_W-1:0] base_q;
   logic [1:0]       ew_q;
   logic [MVL_W-1:0] mvl_q;

   logic [CNT_W-1:0] vl_w;
   logic [CNT_W+2:0] stride_w;
   logic [LW-1:0]    lanes_w;
   logic [LMAX-1:0]  mask_w;
   logic [CNT_W:0]   next_base;
   logic             last_group;

   vlseq_grant #(.CNT_W(CNT_W), .MVL_W(MVL_W)) u_grant (
      .rem_i    (rem_q),
      .mvl64_i  (mvl_q),
      .ew_i     (ew_q),
      .vl_o     (vl_w),
      .stride_o (stride_w)
   );

   vlseq_lane_mask #(.LMAX(LMAX), .CNT_W(CNT_W), .LW(LW)) u_mask (
      .base_i  (base_q),
      .vl_i    (vl_q),
      .lanes_i (lanes_w),
      .en_o    (mask_w)
   );

   always_comb begin
      lanes_w    = LW'(LANES64) << ew_q;
      next_base  = {1'b0, base_q} + (CNT_W+1)'(lanes_w);
      last_group = next_base >= {1'b0, vl_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         vl_q    <= '0;
         base_q  <= '0;
         ew_q    <= EW_64;
         mvl_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_valid) begin
                  rem_q   <= n_i;
                  ew_q    <= ew_i;
                  mvl_q   <= mvl64_i;
                  state_q <= ST_GRANT;
               end
            end
            ST_GRANT: begin
               if (vl_w == '0) begin
                  state_q <= ST_DONE;
               end else begin
                  vl_q    <= vl_w;
                  rem_q   <= rem_q - vl_w;
                  base_q  <= '0;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (last_group) begin
                  base_q  <= '0;
                  state_q <= (rem_q == '0) ? ST_DONE : ST_GRANT;
               end else begin
                  base_q  <= next_base[CNT_W-1:0];
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      start_ready = (state_q == ST_IDLE);
      strip_valid = (state_q == ST_GRANT);
      issue_valid = (state_q == ST_ISSUE);
      done_o      = (state_q == ST_DONE);
      vl_o        = strip_valid ? vl_w     : '0;
      stride_o    = strip_valid ? stride_w : '0;
      base_o      = issue_valid ? base_q   : '0;
      lane_en_o   = issue_valid ? mask_w   : '0;
   end
endmodule

// File: rtl/vl_strip_seq_chk.sv
module vl_strip_seq_chk #(
   parameter int CNT_W = 16,
   parameter int LMAX  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_valid,
   input logic             start_ready,
   input logic             strip_valid,
   input logic [CNT_W-1:0] vl_o,
   input logic [CNT_W+2:0] stride_o,
   input logic             issue_valid,
   input logic [CNT_W-1:0] base_o,
   input logic [LMAX-1:0]  lane_en_o,
   input logic             done_o
);
   // exactly one phase indicator at a time (R8)
   p_one_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({start_ready, strip_valid, issue_valid, done_o}));

   // accepted request is granted on the next cycle (R8)
   p_accept_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid && start_ready |=> strip_valid);

   // zero-length grant goes straight to done (R3)
   p_zero_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      strip_valid && vl_o == '0 |=> done_o);

   // non-empty grant starts issue at element 0 (R2)
   p_strip_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strip_valid && vl_o != '0 |=> issue_valid && base_o == '0);

   // done is a single pulse and returns to idle (R2)
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> start_ready && !done_o);

   // every issued group has lane 0 live (R5)
   p_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> lane_en_o[0]);

   // no lane enabled outside issue cycles (R10)
   p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> lane_en_o == '0);

   // stride covers at least one byte per element (R7)
   p_stride_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strip_valid |-> {3'b000, vl_o} <= stride_o);
endmodule

bind vl_strip_seq vl_strip_seq_chk #(.CNT_W(CNT_W), .LMAX(LMAX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_valid (start_valid),
   .start_ready (start_ready),
   .strip_valid (strip_valid),
   .vl_o        (vl_o),
   .stride_o    (stride_o),
   .issue_valid (issue_valid),
   .base_o      (base_o),
   .lane_en_o   (lane_en_o),
   .done_o      (done_o)
);

// File: tb/tb_vl_strip_seq.sv
module tb_vl_strip_seq;
   localparam int L     = 4;
   localparam int CNT_W = 16;
   localparam int MVL_W = 8;
   localparam int LMAX  = L * 8;

   typedef struct {
      bit              rdy;
      bit              strip;
      int              vl;
      int              stride;
      bit              iss;
      int              base;
      logic [LMAX-1:0] mask;
      bit              done;
   } rec_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_valid = 1'b0;
   logic [CNT_W-1:0] n_i = '0;
   logic [1:0] ew_i = '0;
   logic [MVL_W-1:0] mvl64_i = '0;
   logic start_ready, strip_valid, issue_valid, done_o;
   logic [CNT_W-1:0] vl_o, base_o;
   logic [CNT_W+2:0] stride_o;
   logic [LMAX-1:0] lane_en_o;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;
   string ctx = "reset";
   rec_t expq[$];

   always #2 clk = ~clk;

   vl_strip_seq #(.LANES64(L), .CNT_W(CNT_W), .MVL_W(MVL_W)) dut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
      .n_i(n_i), .ew_i(ew_i), .mvl64_i(mvl64_i), .strip_valid(strip_valid),
      .vl_o(vl_o), .stride_o(stride_o), .issue_valid(issue_valid), .base_o(base_o),
      .lane_en_o(lane_en_o), .done_o(done_o));

   function automatic rec_t idle_rec();
      rec_t r = '{rdy:1, strip:0, vl:0, stride:0, iss:0, base:0, mask:'0, done:0};
      return r;
   endfunction

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   task automatic cmp(string req, int act, int expv);
      compared++;
      if (act != expv) begin
         mismatched++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, ctx, act, expv, $time);
      end
   endtask

   task automatic tick();
      rec_t e;
      @(negedge clk);
      e = (expq.size() > 0) ? expq.pop_front() : idle_rec();
      cmp("R8 start_ready", int'(start_ready), int'(e.rdy));
      cmp("R2 strip_valid", int'(strip_valid), int'(e.strip));
      cmp("R1 vl_o", int'(vl_o), e.vl);
      cmp("R7 stride_o", int'(stride_o), e.stride);
      cmp("R5 issue_valid", int'(issue_valid), int'(e.iss));
      cmp("R5 base_o", int'(base_o), e.base);
      compared++;
      if (lane_en_o !== e.mask) begin
         mismatched++;
         $display("FAIL R5 lane_en_o [%s] actual=%h expected=%h at %0t", ctx, lane_en_o, e.mask, $time);
      end
      cmp("R2 done_o", int'(done_o), int'(e.done));
   endtask

   // reference: per-cycle records of one operation (R1 R2 R3 R5 R6 R7 R11)
   task automatic build(int n, int ew, int m);
      int mv = ((m == 0) ? 1 : m) << ew;
      int lanes = L << ew;
      int rem = n;
      rec_t r;
      forever begin
         int vl = (rem < mv) ? rem : mv;
         r = '{rdy:0, strip:1, vl:vl, stride:vl * (8 >> ew), iss:0, base:0, mask:'0, done:0};
         expq.push_back(r);
         if (vl == 0) break;
         rem -= vl;
         for (int b = 0; b < vl; b += lanes) begin
            r = '{rdy:0, strip:0, vl:0, stride:0, iss:1, base:b, mask:'0, done:0};
            for (int i = 0; i < LMAX; i++) r.mask[i] = (i < lanes) && (b + i < vl);
            expq.push_back(r);
         end
         if (rem == 0) break;
      end
      r = '{rdy:0, strip:0, vl:0, stride:0, iss:0, base:0, mask:'0, done:1};
      expq.push_back(r);
   endtask

   task automatic run_op(string name, int n, int ew, int m, bit poke);
      ctx = name;
      n_i = CNT_W'(n);
      ew_i = 2'(ew);
      mvl64_i = MVL_W'(m);
      start_valid = 1'b1;
      build(n, ew, m);
      tick();
      if (poke) begin
         // R9: a competing request held high while busy
         n_i = CNT_W'(999);
         ew_i = 2'd3;
         mvl64_i = MVL_W'(3);
      end else begin
         start_valid = 1'b0;
      end
      while (expq.size() > 0) begin
         if (expq.size() <= 2) start_valid = 1'b0;
         tick();
      end
      tick();  // idle again, ignored request never started (R9)
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired [%s]", ctx);
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      ctx = "R10 after reset";
      repeat (3) tick();
      run_op("R3 n=0", 0, 0, 64, 0);
      run_op("R1 n=1", 1, 0, 64, 0);
      run_op("R1 n=mvl", 64, 0, 64, 0);
      run_op("R2 n=150 three strips", 150, 0, 64, 0);
      run_op("R5 partial mvl=5", 13, 0, 5, 0);
      run_op("R6 ew32 n=7", 7, 1, 64, 0);
      run_op("R6 ew16 n=300", 300, 2, 64, 0);
      run_op("R6 ew8 n=600", 600, 3, 64, 0);
      run_op("R11 mvl=0", 3, 0, 0, 0);
      run_op("R9 busy start", 150, 0, 64, 1);
      run_op("R3 n=0 ew8", 0, 3, 64, 0);
      run_op("R8 after poke", 9, 1, 2, 0);
      report();
   end
endmodule